// File: doc/BRIEF.md
# Peripheral Interrupt Mask Register Block

This block is the register front end of one peripheral on a 32-bit register bus that only moves whole words. It keeps a status vector that is filled by single-cycle event pulses from the peripheral's own logic, and an interrupt mask. Software never writes the mask as a value. It sets mask bits through one address and clears them through another, and reads the mask back from a third. A bit written as zero at either address leaves that mask bit alone. Software can therefore enable or disable one source with a single write, and it never has to read, modify and write the mask back.

The block also has a command register and a mode register. The command register is write-only, and each bit written as one produces a single-cycle pulse toward the peripheral. The mode register is an ordinary read/write configuration value. The block drives one interrupt-source line toward the interrupt controller. That line is high whenever any status bit is set while its mask bit is also set.

Reads are registered: the data returned by a read appears on the cycle after the read strobe. A read of the status word clears the status bits that were set, so each event is reported once.

Top module: `per_imr_regblk`

## Requirements
- R1: A write to word offset 0x0C sets every mask bit whose write-data bit is one, starting the cycle after the write. Mask bits written as zero keep their value.
- R2: A write to word offset 0x10 clears every mask bit whose write-data bit is one. Mask bits written as zero keep their value.
- R3: Reading offset 0x14 returns the mask in the low N_EVT bits. A write to 0x14 has no effect on the mask.
- R4: `irq_o` is high exactly when some status bit and the mask bit at the same position are both set, using the registered values of the same cycle.
- R5: A write to offset 0x00 drives `cmd_pulse_o` with the low N_CMD write-data bits for exactly one cycle, the cycle after the write. Zero bits give no pulse, and a read of 0x00 returns 0.
- R6: Offset 0x04 is the mode register. It resets to 0, stores the low MODE_W bits of a write, and reads back with all upper bits at 0.
- R7: An event pulse on bit i sets status bit i from the next cycle on. A read of offset 0x08 returns the status and then clears it, except that an event arriving in the same cycle as the read remains set afterwards.
- R8: A write to the status offset 0x08 is ignored. A read of any unmapped offset returns 0. A write to an unmapped offset changes no state.
- R9: `rdata_o` carries the read value in the cycle after `rd_en_i`, and is 0 in any cycle that follows a cycle without a read.
- R10: The two lowest address bits are ignored, so every access is treated as a word access at the enclosing word offset.
- R11: After reset the mask, status, mode, `irq_o`, `cmd_pulse_o` and `rdata_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Byte address within the block |
| wdata_i | input | DATA_W | Write data |
| evt_i | input | N_EVT | Single-cycle event pulses from the peripheral |
| rdata_o | output | DATA_W | Registered read data |
| cmd_pulse_o | output | N_CMD | Single-cycle command pulses |
| irq_o | output | 1 | Interrupt source line |

## Verification
The hardest case to reach from the ports is an event pulse that lands in the same cycle as a status read. In that cycle the returned word must exclude the new event, and the status bit must still be set afterwards. The directed stimulus aligns `evt_i` with a status read on purpose. A random phase then mixes reads, set and clear writes, and events across all offsets, including unmapped ones and addresses with non-zero low bits. A reference model is compared with the outputs after every clock edge.

// File: rtl/per_imr_pkg.sv
package per_imr_pkg;

    // word indices (byte offset >> 2)
    localparam int unsigned WIDX_CMD    = 0;
    localparam int unsigned WIDX_MODE   = 1;
    localparam int unsigned WIDX_STATUS = 2;
    localparam int unsigned WIDX_MSET   = 3;
    localparam int unsigned WIDX_MCLR   = 4;
    localparam int unsigned WIDX_MVIEW  = 5;

    typedef struct packed {
        logic cmd;
        logic mode;
        logic status;
        logic mset;
        logic mclr;
        logic mview;
    } sel_t;

endpackage

// File: rtl/per_imr_decode.sv
module per_imr_decode
    import per_imr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output sel_t              sel_o
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] widx;
    logic             unused_lsb;

    assign widx       = addr_i[ADDR_W-1:2];
    assign unused_lsb = ^addr_i[1:0];

    always_comb begin
        sel_o        = '0;
        sel_o.cmd    = (widx == IDX_W'(WIDX_CMD));
        sel_o.mode   = (widx == IDX_W'(WIDX_MODE));
        sel_o.status = (widx == IDX_W'(WIDX_STATUS));
        sel_o.mset   = (widx == IDX_W'(WIDX_MSET));
        sel_o.mclr   = (widx == IDX_W'(WIDX_MCLR));
        sel_o.mview  = (widx == IDX_W'(WIDX_MVIEW));
    end
endmodule

// File: rtl/per_imr_mask_next.sv
module per_imr_mask_next #(
    parameter int unsigned N_EVT = 8
) (
    input  logic [N_EVT-1:0] mask_q_i,
    input  logic [N_EVT-1:0] bits_i,
    input  logic             set_i,
    input  logic             clr_i,
    output logic [N_EVT-1:0] mask_d_o
);
    for (genvar i = 0; i < N_EVT; i++) begin : g_bit
        always_comb begin
            if (clr_i && bits_i[i]) begin
                mask_d_o[i] = 1'b0;
            end else if (set_i && bits_i[i]) begin
                mask_d_o[i] = 1'b1;
            end else begin
                mask_d_o[i] = mask_q_i[i];
            end
        end
    end
endmodule

// File: rtl/per_imr_reduce.sv
module per_imr_reduce #(
    parameter int unsigned N_EVT = 8
) (
    input  logic [N_EVT-1:0] status_i,
    input  logic [N_EVT-1:0] mask_i,
    output logic             irq_o
);
    logic [N_EVT-1:0] hit;

    assign hit   = status_i & mask_i;
    assign irq_o = |hit;
endmodule

// File: rtl/per_imr_regblk.sv
module per_imr_regblk
    import per_imr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned N_EVT  = 8,
    parameter int unsigned N_CMD  = 4,
    parameter int unsigned MODE_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [N_EVT-1:0]  evt_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [N_CMD-1:0]  cmd_pulse_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [N_EVT-1:0]  status;
        logic [N_EVT-1:0]  mask;
        logic [MODE_W-1:0] mode;
        logic [N_CMD-1:0]  cmd;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t            state_d, state_q;
    sel_t             sel;
    logic [N_EVT-1:0] mask_d;
    logic [N_EVT-1:0] mask_q;
    logic [N_EVT-1:0] status_q;
    logic [DATA_W-1:0] rd_mux;
    logic             unused_wdata;

    assign unused_wdata = ^wdata_i;
    assign mask_q       = state_q.mask;
    assign status_q     = state_q.status;

    per_imr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr_i (addr_i),
        .sel_o  (sel)
    );

    per_imr_mask_next #(.N_EVT(N_EVT)) u_mask (
        .mask_q_i (state_q.mask),
        .bits_i   (wdata_i[N_EVT-1:0]),
        .set_i    (wr_en_i && sel.mset),
        .clr_i    (wr_en_i && sel.mclr),
        .mask_d_o (mask_d)
    );

    per_imr_reduce #(.N_EVT(N_EVT)) u_reduce (
        .status_i (state_q.status),
        .mask_i   (state_q.mask),
        .irq_o    (irq_o)
    );

    always_comb begin
        rd_mux = '0;
        if (sel.mode) begin
            rd_mux = DATA_W'(state_q.mode);
        end else if (sel.status) begin
            rd_mux = DATA_W'(state_q.status);
        end else if (sel.mview) begin
            rd_mux = DATA_W'(state_q.mask);
        end
    end

    always_comb begin
        state_d      = state_q;
        state_d.cmd  = '0;
        state_d.mask = mask_d;
        if (wr_en_i && sel.cmd) begin
            state_d.cmd = wdata_i[N_CMD-1:0];
        end
        if (wr_en_i && sel.mode) begin
            state_d.mode = wdata_i[MODE_W-1:0];
        end
        state_d.status = ((rd_en_i && sel.status) ? '0 : state_q.status) | evt_i;
        state_d.rdata  = rd_en_i ? rd_mux : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rdata_o     = state_q.rdata;
    assign cmd_pulse_o = state_q.cmd;
endmodule

// File: rtl/per_imr_chk.sv
module per_imr_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned N_EVT  = 8,
    parameter int unsigned N_CMD  = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wr_en_i,
    input logic              rd_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic [N_EVT-1:0]  evt_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic [N_CMD-1:0]  cmd_pulse_o,
    input logic              irq_o,
    input logic [N_EVT-1:0]  mask_q,
    input logic [N_EVT-1:0]  status_q
);
    logic [ADDR_W-3:0] widx;
    logic [N_EVT-1:0]  wbits;
    logic              unused_chk;

    assign widx       = addr_i[ADDR_W-1:2];
    assign wbits      = wdata_i[N_EVT-1:0];
    assign unused_chk = ^{addr_i[1:0], wdata_i};

    // R1
    a_r1_set_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && widx == 3) |=> ((mask_q & $past(wbits)) == $past(wbits)));

    // R2
    a_r2_clr_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && widx == 4) |=> ((mask_q & $past(wbits)) == '0));

    // R3: only the two mask addresses move the mask
    a_r3_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_en_i && (widx == 3 || widx == 4)) |=> $stable(mask_q));

    // R4
    a_r4_irq_needs_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (mask_q != '0 && status_q != '0));

    // R5
    a_r5_cmd_origin: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_pulse_o != '0) |-> $past(wr_en_i && widx == 0));

    // R7
    a_r7_evt_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_i != '0) |=> ((status_q & $past(evt_i)) == $past(evt_i)));

    a_r7_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && widx == 2 && evt_i == '0) |=> (status_q == '0));

    // R9
    a_r9_rdata_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> (rdata_o == '0));
endmodule

bind per_imr_regblk per_imr_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .N_EVT  (N_EVT),
    .N_CMD  (N_CMD)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .rd_en_i     (rd_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .evt_i       (evt_i),
    .rdata_o     (rdata_o),
    .cmd_pulse_o (cmd_pulse_o),
    .irq_o       (irq_o),
    .mask_q      (mask_q),
    .status_q    (status_q)
);

// File: tb/per_imr_regblk_tb.sv
`timescale 1ns/1ps
module per_imr_regblk_tb;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        wr_en_i = 1'b0;
    logic        rd_en_i = 1'b0;
    logic [7:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [7:0]  evt_i = '0;
    logic [31:0] rdata_o;
    logic [3:0]  cmd_pulse_o;
    logic        irq_o;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    // reference state
    logic [7:0] m_mask = '0;
    logic [7:0] m_status = '0;
    logic [7:0] m_mode = '0;

    always #2 clk_i = ~clk_i;

    per_imr_regblk u_dut (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_en_i     (wr_en_i),
        .rd_en_i     (rd_en_i),
        .addr_i      (addr_i),
        .wdata_i     (wdata_i),
        .evt_i       (evt_i),
        .rdata_o     (rdata_o),
        .cmd_pulse_o (cmd_pulse_o),
        .irq_o       (irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a[7:2])
            6'd1:    return {24'd0, m_mode};
            6'd2:    return {24'd0, m_status};
            6'd5:    return {24'd0, m_mask};
            default: return 32'd0;
        endcase
    endfunction

    // one bus cycle: drive at negedge, check just after the posedge
    task automatic step(input logic wr, input logic rd, input logic [7:0] a,
                        input logic [31:0] wd, input logic [7:0] ev, input string tag);
        logic [31:0] exp_rd;
        logic [3:0]  exp_cmd;
        @(negedge clk_i);
        wr_en_i = wr; rd_en_i = rd; addr_i = a; wdata_i = wd; evt_i = ev;
        exp_rd  = rd ? model_read(a) : 32'd0;
        exp_cmd = (wr && a[7:2] == 6'd0) ? wd[3:0] : 4'd0;
        if (wr && a[7:2] == 6'd1) m_mode = wd[7:0];
        if (wr && a[7:2] == 6'd3) m_mask = m_mask | wd[7:0];
        if (wr && a[7:2] == 6'd4) m_mask = m_mask & ~wd[7:0];
        if (rd && a[7:2] == 6'd2) m_status = '0;
        m_status = m_status | ev;
        @(posedge clk_i);
        #1;
        check({tag, " rdata R9"}, rdata_o, exp_rd);
        check({tag, " cmd R5"}, {28'd0, cmd_pulse_o}, {28'd0, exp_cmd});
        check({tag, " irq R4"}, {31'd0, irq_o}, {31'd0, |(m_status & m_mask)});
    endtask

    initial begin
        #200000;
        if (!done) begin
            mismatched++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk_i);
        // R11 reset state
        check("R11 rdata", rdata_o, 32'd0);
        check("R11 cmd", {28'd0, cmd_pulse_o}, 32'd0);
        check("R11 irq", {31'd0, irq_o}, 32'd0);
        rst_ni = 1'b1;

        step(0, 1, 8'h04, 0, 0, "R11 mode reset");
        step(0, 1, 8'h14, 0, 0, "R11 mask reset");
        step(0, 1, 8'h08, 0, 0, "R11 status reset");
        // R6 mode
        step(1, 0, 8'h04, 32'hFFFF_FFA5, 0, "R6 write");
        step(0, 1, 8'h04, 0, 0, "R6 readback");
        // R1 set, R10 low bits ignored
        step(1, 0, 8'h0C, 32'h0F, 0, "R1 set");
        step(1, 0, 8'h0C, 32'h30, 0, "R1 set more");
        step(1, 0, 8'h0F, 32'h80, 0, "R10 set via 0x0F");
        step(0, 1, 8'h16, 0, 0, "R1 R10 mask view");
        // R2 clear
        step(1, 0, 8'h10, 32'h05, 0, "R2 clear");
        step(0, 1, 8'h14, 0, 0, "R2 mask view");
        // R3 write to view ignored
        step(1, 0, 8'h14, 32'hFF, 0, "R3 write view");
        step(0, 1, 8'h14, 0, 0, "R3 mask view");
        // R7 events, R4 irq
        step(0, 0, 8'h00, 0, 8'h03, "R7 event");
        step(0, 0, 8'h00, 0, 0, "R4 irq high");
        step(0, 1, 8'h08, 0, 0, "R7 read clears");
        step(0, 1, 8'h08, 0, 0, "R7 after clear");
        step(0, 0, 8'h00, 0, 8'h40, "R7 event 6");
        step(0, 1, 8'h08, 0, 8'h01, "R7 event during read");
        step(0, 1, 8'h08, 0, 0, "R7 kept bit");
        // R4 masked status gives no irq
        step(0, 0, 8'h00, 0, 8'h04, "R4 unmasked event");
        step(0, 0, 8'h00, 0, 0, "R4 irq low");
        // R8 status write ignored, unmapped
        step(1, 0, 8'h08, 32'hFF, 0, "R8 status write");
        step(0, 1, 8'h08, 0, 0, "R8 status unchanged");
        step(1, 0, 8'h40, 32'hFFFF_FFFF, 0, "R8 unmapped write");
        step(0, 1, 8'h40, 0, 0, "R8 unmapped read");
        step(0, 1, 8'h04, 0, 0, "R8 mode intact");
        step(0, 1, 8'h14, 0, 0, "R8 mask intact");
        // R5 commands
        step(1, 0, 8'h00, 32'h5, 0, "R5 cmd");
        step(0, 0, 8'h00, 0, 0, "R5 pulse ends");
        step(1, 0, 8'h00, 32'hA, 0, "R5 cmd b2b 1");
        step(1, 0, 8'h00, 32'h0, 0, "R5 cmd zero");
        step(0, 1, 8'h00, 0, 0, "R5 cmd read zero");
        // R1 R2 zeros leave bits alone
        step(1, 0, 8'h0C, 32'h00, 0, "R1 zero set");
        step(1, 0, 8'h10, 32'h00, 0, "R2 zero clear");
        step(0, 1, 8'h14, 0, 0, "R1 R2 mask view");

        // mixed random traffic
        for (int i = 0; i < 400; i++) begin
            logic [7:0] a;
            logic [2:0] pick;
            pick = 3'($urandom_range(0, 7));
            a = {pick == 3'd7 ? 3'd2 : 3'd0, pick, 2'($urandom_range(0, 3))};
            step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a,
                 $urandom, ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'd0,
                 "R7 R1 R2 random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule